// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block sits next to a 64-bit memory datapath whose ECC logic already classifies every access. Each cycle the datapath may present an access carrying a correctable-error flag, an uncorrectable-error flag, the access address, the raw 64-bit data and the check/syndrome bits. The unit keeps sticky detect flags, records the first error it sees, counts correctable errors against a programmable threshold, and raises a level interrupt from the flags that software has enabled.

Software reaches the unit through a 32-bit word-addressed register port with a one-cycle registered read. The same port loads three error-injection words: a high data mask, a low data mask and an ECC control word. These drive straight out to the datapath, which XORs them onto write data and check bits. The ECC arithmetic, the memory controller and the DRAM interface are not part of this block.

Top module: `eccerr_unit`

## Requirements
- R1: After reset, every detect flag, capture word, injection output and `irq` is 0. The threshold field reads 1, and `reg_rdata` is 0.
- R2: An uncorrectable access sets bit 1 of the detect word (word 0). It captures data bits 63:32 into word 5, data bits 31:0 into word 6, the check value into word 7 and the address into word 8.
- R3: Writing word 0 clears each flag whose bit in the write data is 1: bit 0 correctable, bit 1 uncorrectable, bit 31 overflow. Flags written with 0 are kept. When an error sets a flag in the same cycle that a write clears it, the flag stays set.
- R4: Each correctable access advances a counter that reads in bits 7:0 of word 3. When counter+1 reaches the threshold in bits 23:16 of word 3, bit 0 of word 0 is set, the counter returns to 0 and the access is captured. A threshold of 0 acts as 1, and any write to word 3 clears the counter.
- R5: Word 2 bit 0 enables the correctable flag onto `irq` and bit 1 enables the uncorrectable flag. `irq` is the OR of the enabled set flags, registered one cycle after the flags.
- R6: Word 1 bit 0 suppresses correctable detection, counting and capture. Word 1 bit 1 does the same for uncorrectable errors.
- R7: Word 4 bit 0 selects the bus width: 1 is 32-bit and 0 is 64-bit. A 32-bit bus keeps the low 16 bits of the captured check value; a 64-bit bus keeps the low 8 bits.
- R8: While bit 0 or bit 1 of word 0 is set, a correctable event does not recapture and sets bit 31. An uncorrectable event recaptures, without setting bit 31, unless bit 1 is already set. If bit 1 is already set, it sets bit 31 and keeps the capture.
- R9: Words 9, 10 and 11 read back as written and drive `inj_data_hi`, `inj_data_lo` and `inj_ecc_ctl`.
- R10: Reads of words 12 to 15 return 0, and writes to words 5 to 8 leave them unchanged.
- R11: An access flagged both correctable and uncorrectable is handled as uncorrectable only, and the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Access checked by the ECC datapath this cycle |
| ev_sbe | input | 1 | Access had a correctable error |
| ev_mbe | input | 1 | Access had an uncorrectable error |
| ev_addr | input | ADDR_W | Access address |
| ev_data | input | DATA_W | Raw data read from memory |
| ev_check | input | CHK_W | Check/syndrome bits of the access |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| inj_data_hi | output | 32 | Injection mask for data bits 63:32 |
| inj_data_lo | output | 32 | Injection mask for data bits 31:0 |
| inj_ecc_ctl | output | 32 | ECC injection control word |
| irq | output | 1 | Error interrupt |

## Verification
The assertions check four things on every cycle. A set flag stays set unless word 0 is written with a 1 in its bit. A disabled error type never sets its flag. The counter stays below the threshold. The interrupt follows the enabled flags one cycle later. The freeze of the capture words while a flag is pending is also checked each cycle, away from uncorrectable events. Only the directed scenarios can show the rest: the captured values themselves, the exact threshold crossing, the overwrite ordering between the two error types, syndrome truncation per bus width, and the behaviour of an error that collides with a clear.

// File: rtl/eccerr_pkg.sv
package eccerr_pkg;
  localparam int unsigned RA_W = 4;

  localparam logic [RA_W-1:0] OFS_DETECT   = 4'd0;
  localparam logic [RA_W-1:0] OFS_DISABLE  = 4'd1;
  localparam logic [RA_W-1:0] OFS_INTEN    = 4'd2;
  localparam logic [RA_W-1:0] OFS_SBECTL   = 4'd3;
  localparam logic [RA_W-1:0] OFS_CFG      = 4'd4;
  localparam logic [RA_W-1:0] OFS_CAP_HI   = 4'd5;
  localparam logic [RA_W-1:0] OFS_CAP_LO   = 4'd6;
  localparam logic [RA_W-1:0] OFS_CAP_CHK  = 4'd7;
  localparam logic [RA_W-1:0] OFS_CAP_ADDR = 4'd8;
  localparam logic [RA_W-1:0] OFS_INJ_HI   = 4'd9;
  localparam logic [RA_W-1:0] OFS_INJ_LO   = 4'd10;
  localparam logic [RA_W-1:0] OFS_INJ_CTL  = 4'd11;

  localparam int unsigned BIT_SBE   = 0;
  localparam int unsigned BIT_MBE   = 1;
  localparam int unsigned BIT_MULTI = 31;
  localparam int unsigned THR_LSB   = 16;

  typedef struct packed {
    logic multi;
    logic mbe;
    logic sbe;
  } flags_t;
endpackage

// File: rtl/eccerr_sbe_count.sv
module eccerr_sbe_count #(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sbe_in,
  input  logic             thr_wr,
  input  logic [THR_W-1:0] thr,
  output logic [THR_W-1:0] cnt,
  output logic             hit
);
  logic [THR_W-1:0] cnt_q;
  logic [THR_W:0]   inc;

  always_comb begin
    inc = {1'b0, cnt_q} + 1'b1;
    hit = sbe_in && (inc >= {1'b0, thr});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (thr_wr || hit) begin
      cnt_q <= '0;
    end else if (sbe_in) begin
      cnt_q <= inc[THR_W-1:0];
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/eccerr_capture.sv
module eccerr_capture
  import eccerr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned CHK_W      = 16,
  parameter int unsigned SYN_WIDE   = 8,
  parameter int unsigned SYN_NARROW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sbe_ev,
  input  logic                mbe_ev,
  input  logic                narrow,
  input  logic [ADDR_W-1:0]   ev_addr,
  input  logic [DATA_W-1:0]   ev_data,
  input  logic [CHK_W-1:0]    ev_check,
  input  logic                clr_wr,
  input  logic [31:0]         clr_mask,
  output flags_t              flags,
  output logic [DATA_W/2-1:0] cap_hi,
  output logic [DATA_W/2-1:0] cap_lo,
  output logic [CHK_W-1:0]    cap_chk,
  output logic [ADDR_W-1:0]   cap_addr
);
  localparam int unsigned HALF_W = DATA_W / 2;

  flags_t            flg_q, flg_d;
  logic              frozen, take, mset;
  logic [CHK_W-1:0]  chk_m;
  int unsigned       keep_w;

  always_comb begin
    frozen = flg_q.sbe | flg_q.mbe;
    if (mbe_ev) begin
      take = !flg_q.mbe;
      mset = flg_q.mbe;
    end else begin
      take = sbe_ev && !frozen;
      mset = sbe_ev && frozen;
    end
    flg_d.sbe   = sbe_ev | (flg_q.sbe   & ~(clr_wr & clr_mask[BIT_SBE]));
    flg_d.mbe   = mbe_ev | (flg_q.mbe   & ~(clr_wr & clr_mask[BIT_MBE]));
    flg_d.multi = mset   | (flg_q.multi & ~(clr_wr & clr_mask[BIT_MULTI]));
  end

  always_comb begin
    keep_w = narrow ? SYN_NARROW : SYN_WIDE;
    for (int i = 0; i < int'(CHK_W); i++) begin
      chk_m[i] = ev_check[i] && (i < int'(keep_w));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q    <= '0;
      cap_hi   <= '0;
      cap_lo   <= '0;
      cap_chk  <= '0;
      cap_addr <= '0;
    end else begin
      flg_q <= flg_d;
      if (take) begin
        cap_hi   <= ev_data[DATA_W-1:HALF_W];
        cap_lo   <= ev_data[HALF_W-1:0];
        cap_chk  <= chk_m;
        cap_addr <= ev_addr;
      end
    end
  end

  assign flags = flg_q;
endmodule

// File: rtl/eccerr_csr.sv
module eccerr_csr
  import eccerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned CHK_W  = 16,
  parameter int unsigned THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  flags_t            flags,
  input  logic [HALF_W-1:0] cap_hi,
  input  logic [HALF_W-1:0] cap_lo,
  input  logic [CHK_W-1:0]  cap_chk,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [THR_W-1:0]  cnt,
  output logic [1:0]        dis,
  output logic [1:0]        inten,
  output logic [THR_W-1:0]  thr,
  output logic              thr_wr,
  output logic              det_wr,
  output logic              narrow,
  output logic [31:0]       inj_hi,
  output logic [31:0]       inj_lo,
  output logic [31:0]       inj_ctl
);
  logic        wr, rd;
  logic [31:0] rmux, det_word;

  always_comb begin
    wr     = reg_en && reg_we;
    rd     = reg_en && !reg_we;
    thr_wr = wr && (reg_addr == OFS_SBECTL);
    det_wr = wr && (reg_addr == OFS_DETECT);
    det_word = '0;
    det_word[BIT_SBE]   = flags.sbe;
    det_word[BIT_MBE]   = flags.mbe;
    det_word[BIT_MULTI] = flags.multi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis     <= '0;
      inten   <= '0;
      thr     <= THR_W'(1);
      narrow  <= 1'b0;
      inj_hi  <= '0;
      inj_lo  <= '0;
      inj_ctl <= '0;
    end else if (wr) begin
      case (reg_addr)
        OFS_DISABLE: dis     <= reg_wdata[1:0];
        OFS_INTEN:   inten   <= reg_wdata[1:0];
        OFS_SBECTL:  thr     <= reg_wdata[THR_LSB +: THR_W];
        OFS_CFG:     narrow  <= reg_wdata[0];
        OFS_INJ_HI:  inj_hi  <= reg_wdata;
        OFS_INJ_LO:  inj_lo  <= reg_wdata;
        OFS_INJ_CTL: inj_ctl <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_DETECT:   rmux = det_word;
      OFS_DISABLE:  rmux = 32'(dis);
      OFS_INTEN:    rmux = 32'(inten);
      OFS_SBECTL:   rmux = (32'(thr) << THR_LSB) | 32'(cnt);
      OFS_CFG:      rmux = 32'(narrow);
      OFS_CAP_HI:   rmux = 32'(cap_hi);
      OFS_CAP_LO:   rmux = 32'(cap_lo);
      OFS_CAP_CHK:  rmux = 32'(cap_chk);
      OFS_CAP_ADDR: rmux = 32'(cap_addr);
      OFS_INJ_HI:   rmux = inj_hi;
      OFS_INJ_LO:   rmux = inj_lo;
      OFS_INJ_CTL:  rmux = inj_ctl;
      default:      rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd ? rmux : '0;
  end
endmodule

// File: rtl/eccerr_unit.sv
module eccerr_unit
  import eccerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 16,
  parameter int unsigned THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_sbe,
  input  logic              ev_mbe,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic [CHK_W-1:0]  ev_check,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       inj_data_hi,
  output logic [31:0]       inj_data_lo,
  output logic [31:0]       inj_ecc_ctl,
  output logic              irq
);
  localparam int unsigned HALF_W = DATA_W / 2;

  flags_t            flags_w;
  logic [HALF_W-1:0] cap_hi_w, cap_lo_w;
  logic [CHK_W-1:0]  cap_chk_w;
  logic [ADDR_W-1:0] cap_addr_w;
  logic [THR_W-1:0]  cnt_w, thr_w;
  logic [1:0]        dis_w, inten_w;
  logic              thr_wr_w, det_wr_w, narrow_w;
  logic              sbe_raw, mbe_ev, sbe_hit;

  always_comb begin
    mbe_ev  = ev_valid && ev_mbe && !dis_w[BIT_MBE];
    sbe_raw = ev_valid && ev_sbe && !ev_mbe && !dis_w[BIT_SBE];
  end

  eccerr_sbe_count #(.THR_W(THR_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .sbe_in (sbe_raw),
    .thr_wr (thr_wr_w),
    .thr    (thr_w),
    .cnt    (cnt_w),
    .hit    (sbe_hit)
  );

  eccerr_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .sbe_ev   (sbe_hit),
    .mbe_ev   (mbe_ev),
    .narrow   (narrow_w),
    .ev_addr  (ev_addr),
    .ev_data  (ev_data),
    .ev_check (ev_check),
    .clr_wr   (det_wr_w),
    .clr_mask (reg_wdata),
    .flags    (flags_w),
    .cap_hi   (cap_hi_w),
    .cap_lo   (cap_lo_w),
    .cap_chk  (cap_chk_w),
    .cap_addr (cap_addr_w)
  );

  eccerr_csr #(
    .ADDR_W (ADDR_W),
    .HALF_W (HALF_W),
    .CHK_W  (CHK_W),
    .THR_W  (THR_W)
  ) u_csr (
    .clk       (clk),
    .rst       (rst),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .flags     (flags_w),
    .cap_hi    (cap_hi_w),
    .cap_lo    (cap_lo_w),
    .cap_chk   (cap_chk_w),
    .cap_addr  (cap_addr_w),
    .cnt       (cnt_w),
    .dis       (dis_w),
    .inten     (inten_w),
    .thr       (thr_w),
    .thr_wr    (thr_wr_w),
    .det_wr    (det_wr_w),
    .narrow    (narrow_w),
    .inj_hi    (inj_data_hi),
    .inj_lo    (inj_data_lo),
    .inj_ctl   (inj_ecc_ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (flags_w.sbe && inten_w[BIT_SBE]) || (flags_w.mbe && inten_w[BIT_MBE]);
  end
endmodule

// File: rtl/eccerr_unit_chk.sv
module eccerr_unit_chk #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned THR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_en,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              ev_valid,
  input logic              ev_mbe,
  input logic [2:0]        flags,
  input logic [1:0]        inten,
  input logic [1:0]        dis,
  input logic [THR_W-1:0]  cnt,
  input logic [THR_W-1:0]  thr,
  input logic [HALF_W-1:0] cap_lo,
  input logic              irq
);
  logic det_clr0;
  assign det_clr0 = reg_en && reg_we && (reg_addr == 4'd0) && reg_wdata[0];

  p_sticky_sbe_r3: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !det_clr0) |=> flags[0]);

  p_cap_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    ((flags[0] || flags[1]) && !(ev_valid && ev_mbe)) |=> $stable(cap_lo));

  p_mbe_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (dis[1] && !flags[1]) |=> !flags[1]);

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt < thr) || (cnt == '0));

  p_irq_raise_r5: assert property (@(posedge clk) disable iff (rst)
    ((flags[0] && inten[0]) || (flags[1] && inten[1])) |=> irq);

  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (inten == 2'b00) |=> !irq);
endmodule

bind eccerr_unit eccerr_unit_chk #(.HALF_W(DATA_W/2), .THR_W(THR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_en    (reg_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ev_valid  (ev_valid),
  .ev_mbe    (ev_mbe),
  .flags     (flags_w),
  .inten     (inten_w),
  .dis       (dis_w),
  .cnt       (cnt_w),
  .thr       (thr_w),
  .cap_lo    (cap_lo_w),
  .irq       (irq)
);

// File: tb/eccerr_unit_tb.sv
module eccerr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0, ev_sbe = 1'b0, ev_mbe = 1'b0;
  logic [31:0] ev_addr = '0;
  logic [63:0] ev_data = '0;
  logic [15:0] ev_check = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, inj_data_hi, inj_data_lo, inj_ecc_ctl;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  eccerr_unit u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_sbe(ev_sbe), .ev_mbe(ev_mbe),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_check(ev_check),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .inj_data_hi(inj_data_hi), .inj_data_lo(inj_data_lo),
    .inj_ecc_ctl(inj_ecc_ctl), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ev(input logic s, input logic m, input logic [31:0] a,
                    input logic [63:0] d, input logic [15:0] c);
    @(negedge clk);
    ev_valid = 1'b1; ev_sbe = s; ev_mbe = m; ev_addr = a; ev_data = d; ev_check = c;
    @(negedge clk);
    ev_valid = 1'b0; ev_sbe = 1'b0; ev_mbe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 inj_hi", inj_data_hi, 0);
    chk("R1 inj_ctl", inj_ecc_ctl, 0);
    rd_chk("R1 detect", 4'd0, 32'h0);
    rd_chk("R1 threshold", 4'd3, 32'h0001_0000);
    rd_chk("R1 cap_lo", 4'd6, 32'h0);
  endtask

  task automatic t_mbe_capture();
    ev(1'b0, 1'b1, 32'h1234_5670, 64'hA5A5_0F0F_1357_9BDF, 16'h01FF);
    rd_chk("R2 detect", 4'd0, 32'h2);
    rd_chk("R2 cap_hi", 4'd5, 32'hA5A5_0F0F);
    rd_chk("R2 cap_lo", 4'd6, 32'h1357_9BDF);
    rd_chk("R2/R7 cap_chk wide", 4'd7, 32'h0000_00FF);
    rd_chk("R2 cap_addr", 4'd8, 32'h1234_5670);
    chk("R5 irq masked", 32'(irq), 0);
    wr(4'd2, 32'h2);
    idle();
    chk("R5 irq mbe enabled", 32'(irq), 1);
    wr(4'd0, 32'h8000_0003);
    rd_chk("R3 detect cleared", 4'd0, 32'h0);
    chk("R5 irq drops", 32'(irq), 0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_threshold();
    wr(4'd3, 32'h0003_0000);
    ev(1'b1, 1'b0, 32'h100, 64'h1, 16'h3);
    ev(1'b1, 1'b0, 32'h200, 64'h2, 16'h3);
    rd_chk("R4 below threshold", 4'd0, 32'h0);
    rd_chk("R4 count", 4'd3, 32'h0003_0002);
    ev(1'b1, 1'b0, 32'h300, 64'h3, 16'h3);
    rd_chk("R4 flag at threshold", 4'd0, 32'h1);
    rd_chk("R4 count reset", 4'd3, 32'h0003_0000);
    rd_chk("R4 capture", 4'd6, 32'h3);
    wr(4'd0, 32'hFFFF_FFFF);
    ev(1'b1, 1'b0, 32'h0, 64'h4, 16'h0);
    wr(4'd3, 32'h0003_0000);
    rd_chk("R4 write clears count", 4'd3, 32'h0003_0000);
    wr(4'd3, 32'h0000_0000);
    ev(1'b1, 1'b0, 32'h0, 64'h5, 16'h0);
    rd_chk("R4 zero threshold acts as one", 4'd0, 32'h1);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd3, 32'h0001_0000);
  endtask

  task automatic t_freeze();
    ev(1'b1, 1'b0, 32'h10, 64'hA, 16'h0);
    rd_chk("R8 first sbe", 4'd0, 32'h1);
    ev(1'b1, 1'b0, 32'h20, 64'hB, 16'h0);
    rd_chk("R8 overflow flag", 4'd0, 32'h8000_0001);
    rd_chk("R8 capture kept", 4'd6, 32'hA);
    ev(1'b0, 1'b1, 32'h30, 64'hC, 16'h0);
    rd_chk("R8 mbe over sbe flags", 4'd0, 32'h8000_0003);
    rd_chk("R8 mbe overwrites", 4'd6, 32'hC);
    ev(1'b0, 1'b1, 32'h40, 64'hD, 16'h0);
    rd_chk("R8 second mbe kept", 4'd6, 32'hC);
    wr(4'd0, 32'h0000_0002);
    rd_chk("R3 partial clear", 4'd0, 32'h8000_0001);
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk("R3 clear all", 4'd0, 32'h0);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1;
    ev_valid = 1'b1; ev_sbe = 1'b1; ev_data = 64'hE;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; ev_valid = 1'b0; ev_sbe = 1'b0;
    rd_chk("R3 set wins over clear", 4'd0, 32'h1);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_disable();
    wr(4'd1, 32'h3);
    ev(1'b0, 1'b1, 32'h50, 64'hF0, 16'h0);
    ev(1'b1, 1'b0, 32'h60, 64'hF1, 16'h0);
    rd_chk("R6 no flags", 4'd0, 32'h0);
    rd_chk("R6 no capture", 4'd6, 32'hE);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_narrow();
    wr(4'd4, 32'h1);
    ev(1'b0, 1'b1, 32'h70, 64'h0, 16'hABCD);
    rd_chk("R7 narrow syndrome", 4'd7, 32'h0000_ABCD);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0);
    ev(1'b0, 1'b1, 32'h70, 64'h0, 16'hABCD);
    rd_chk("R7 wide syndrome", 4'd7, 32'h0000_00CD);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_both();
    ev(1'b1, 1'b1, 32'h80, 64'h77, 16'h0);
    rd_chk("R11 only mbe", 4'd0, 32'h2);
    rd_chk("R11 count unchanged", 4'd3, 32'h0001_0000);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq_sbe();
    wr(4'd2, 32'h1);
    ev(1'b1, 1'b0, 32'h90, 64'h9, 16'h0);
    idle();
    chk("R5 irq sbe", 32'(irq), 1);
    wr(4'd2, 32'h0);
    idle();
    chk("R5 irq disabled", 32'(irq), 0);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_inject();
    wr(4'd9, 32'hDEAD_BEEF);
    wr(4'd10, 32'h0000_0001);
    wr(4'd11, 32'h0000_0080);
    chk("R9 inj_hi out", inj_data_hi, 32'hDEAD_BEEF);
    chk("R9 inj_lo out", inj_data_lo, 32'h0000_0001);
    chk("R9 inj_ctl out", inj_ecc_ctl, 32'h0000_0080);
    rd_chk("R9 inj_lo readback", 4'd10, 32'h0000_0001);
  endtask

  task automatic t_unmapped();
    rd_chk("R10 word 12", 4'd12, 32'h0);
    rd_chk("R10 word 15", 4'd15, 32'h0);
    wr(4'd6, 32'h5555_5555);
    rd_chk("R10 capture write ignored", 4'd6, 32'h9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mbe_capture();
    t_threshold();
    t_freeze();
    t_disable();
    t_narrow();
    t_both();
    t_irq_sbe();
    t_inject();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule